// File: doc/BRIEF.md
# Windowed Watchdog Timer with Prewarning

This block supervises firmware by counting watchdog clock cycles while it is enabled. Firmware proves it is alive by writing a fixed 32-bit key to a service address. The write must fall inside a window that two programmable bounds define. An accepted feed returns the counter to zero and drives a service-indication pulse of programmable width. A feed that comes too early or carries any other value raises a system reset request. A counter that runs past the upper bound raises the same request. The request is sticky.

In prewarning mode, the first overrun does not reset the system. It raises an alarm and restarts the count, so firmware gets a second full period to react. Firmware clears the alarm by writing to a separate clear address, and it must still feed within the window. Two further controls affect counting. A debug-halt input freezes the counter unless a debug-run control bit is set. Clearing the enable bit pauses the counter and keeps its value.

All settings sit behind a small word-wide register port. Writes take effect at a clock edge. Reads are combinational. The address map is: 0 control, 1 lower bound, 2 upper bound, 3 counter (read), 4 service (write), 5 alarm clear (write).

Top module: `wdog_top`

## Requirements
- R1: After reset the counter reads 0 at address 3, all three outputs are low, the control word reads 0, the lower bound reads 0 and the upper bound reads all ones. While enabled, the counter advances by one on each watchdog clock.
- R2: A write of 0xABADCAFE to address 4 is accepted when the counter is at least the lower bound and at most the upper bound. An accepted write clears the counter to 0 at that edge and leaves the reset request low.
- R3: A service write while the counter is below a nonzero lower bound raises the reset request at that edge.
- R4: A lower bound of 0 disables the early check, so a correct key is accepted at any count from 0 up to the upper bound.
- R5: A service write with any value other than 0xABADCAFE raises the reset request at that edge.
- R6: In timeout mode (control bit 1 = 0), the reset request rises at the first counting edge after the counter reaches the upper bound. This also holds when the upper bound is set below the lower bound.
- R7: In prewarning mode (control bit 1 = 1), the first overrun sets the alarm output and restarts the counter from 0. It does not raise the reset request.
- R8: In prewarning mode, a later overrun raises the reset request in two cases: while the alarm is still set, or when no accepted feed has occurred since the previous overrun. An overrun after both an alarm clear and an accepted feed counts as a first overrun again.
- R9: Writing data with bit 0 set to address 5 clears the alarm output at that edge.
- R10: Each accepted feed drives the service pulse high for SPW+1 clock cycles, where SPW is control bits 15:8. The pulse starts right after the accepting edge.
- R11: While the debug-halt input is high and control bit 4 (debug-run) is 0, the counter holds its value. With bit 4 set, the counter keeps advancing during halt.
- R12: Clearing control bit 0 (enable) pauses the counter at its value, and setting it again resumes counting. While the watchdog is disabled, service writes have no effect on the counter or the reset request.
- R13: Once raised, the reset request stays high until the block's own reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data (combinational) |
| dbgHalt | input | 1 | Debug halt indication |
| svcPulse | output | 1 | Service-indication pulse |
| alarmOut | output | 1 | Prewarning alarm |
| rstReq | output | 1 | Sticky system reset request |

## Verification
The hardest situations to reach are the prewarning sequences. They require an overrun, then a chosen mix of alarm clear and feed, then a second overrun. Each ordering must separately produce or withhold the reset request. The bench drives each ordering from a fresh reset with a short upper bound, so each second overrun arrives within a few cycles.

The bench also sweeps a feed at every count from 0 to the upper bound, under both a zero and a nonzero lower bound. To make each feed land on a known count, it polls the counter readback at the falling edge. It issues the write only when the readback equals the target.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DW       = 32;
  localparam int AW       = 3;
  localparam int SPW_W    = 8;
  localparam int SPW_LSB  = 8;
  localparam int PRE_BIT  = 1;
  localparam int DBG_BIT  = 4;
  localparam int EN_BIT   = 0;
  localparam logic [DW-1:0] FEED_KEY = 32'hABADCAFE;

  localparam logic [AW-1:0] A_CTRL  = 3'd0;
  localparam logic [AW-1:0] A_LOWER = 3'd1;
  localparam logic [AW-1:0] A_UPPER = 3'd2;
  localparam logic [AW-1:0] A_COUNT = 3'd3;
  localparam logic [AW-1:0] A_SVC   = 3'd4;
  localparam logic [AW-1:0] A_CLR   = 3'd5;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
  } cntStrobe_t;

  typedef struct packed {
    logic             enable;
    logic             prewarn;
    logic             dbgRun;
    logic [SPW_W-1:0] spw;
    logic [DW-1:0]    lower;
    logic [DW-1:0]    upper;
  } wdCfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] cntVal,
  output wdCfg_t            cfg,
  output logic [DATA_W-1:0] busRdata,
  output logic              svcWr,
  output logic              almClrWr
);
  wdCfg_t cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ.enable  <= 1'b0;
      cfgQ.prewarn <= 1'b0;
      cfgQ.dbgRun  <= 1'b0;
      cfgQ.spw     <= '0;
      cfgQ.lower   <= '0;
      cfgQ.upper   <= '1;
    end else if (busWe) begin
      unique case (busAddr)
        A_CTRL: begin
          cfgQ.enable  <= busWdata[EN_BIT];
          cfgQ.prewarn <= busWdata[PRE_BIT];
          cfgQ.dbgRun  <= busWdata[DBG_BIT];
          cfgQ.spw     <= busWdata[SPW_LSB +: SPW_W];
        end
        A_LOWER: cfgQ.lower <= busWdata;
        A_UPPER: cfgQ.upper <= busWdata;
        default: ;
      endcase
    end
  end

  assign cfg      = cfgQ;
  assign svcWr    = busWe && (busAddr == A_SVC);
  assign almClrWr = busWe && (busAddr == A_CLR) && busWdata[0];

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      A_CTRL: begin
        busRdata[EN_BIT]               = cfgQ.enable;
        busRdata[PRE_BIT]              = cfgQ.prewarn;
        busRdata[DBG_BIT]              = cfgQ.dbgRun;
        busRdata[SPW_LSB +: SPW_W]     = cfgQ.spw;
      end
      A_LOWER: busRdata = cfgQ.lower;
      A_UPPER: busRdata = cfgQ.upper;
      A_COUNT: busRdata = cntVal;
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_dpath.sv
module wdog_dpath
  import wdog_pkg::*;
#(
  parameter int CNT_W = DW
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] lower,
  input  logic [CNT_W-1:0] upper,
  output logic [CNT_W-1:0] cntVal,
  output logic             atUpper,
  output logic             tooEarly
);
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntQ <= '0;
    else if (strobe.clrCnt) cntQ <= '0;
    else if (strobe.incCnt) cntQ <= cntQ + CNT_W'(1);
  end

  assign cntVal   = cntQ;
  assign atUpper  = (cntQ >= upper);
  assign tooEarly = (lower != '0) && (cntQ < lower);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int PW_W   = SPW_W,
  parameter logic [DATA_W-1:0] KEY = FEED_KEY
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              prewarn,
  input  logic              dbgRun,
  input  logic [PW_W-1:0]   spw,
  input  logic              dbgHalt,
  input  logic              svcWr,
  input  logic [DATA_W-1:0] svcData,
  input  logic              almClrWr,
  input  logic              atUpper,
  input  logic              tooEarly,
  output cntStrobe_t        strobe,
  output logic              svcPulse,
  output logic              alarmOut,
  output logic              rstReq
);
  logic active, feedWr, keyOk, feedGood, feedBad;
  logic ovf, firstWarn, ovfReset;
  logic alarmQ, pendQ, rstQ, pulseOn;
  logic [PW_W-1:0] pulseLeft;

  assign active    = enable && !(dbgHalt && !dbgRun);
  assign feedWr    = svcWr && enable;
  assign keyOk     = (svcData == KEY);
  assign feedGood  = feedWr && keyOk && !tooEarly;
  assign feedBad   = feedWr && !(keyOk && !tooEarly);
  assign ovf       = active && atUpper && !feedGood;
  assign firstWarn = ovf && prewarn && !alarmQ && !pendQ;
  assign ovfReset  = ovf && !firstWarn;

  assign strobe.clrCnt = feedGood || firstWarn;
  assign strobe.incCnt = active && !atUpper;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstQ      <= 1'b0;
      alarmQ    <= 1'b0;
      pendQ     <= 1'b0;
      pulseOn   <= 1'b0;
      pulseLeft <= '0;
    end else begin
      if (feedBad || ovfReset) rstQ <= 1'b1;

      if (firstWarn)     alarmQ <= 1'b1;
      else if (almClrWr) alarmQ <= 1'b0;

      if (feedGood)       pendQ <= 1'b0;
      else if (firstWarn) pendQ <= 1'b1;

      if (feedGood) begin
        pulseOn   <= 1'b1;
        pulseLeft <= spw;
      end else if (pulseOn) begin
        if (pulseLeft == '0) pulseOn <= 1'b0;
        else                 pulseLeft <= pulseLeft - PW_W'(1);
      end
    end
  end

  assign svcPulse = pulseOn;
  assign alarmOut = alarmQ;
  assign rstReq   = rstQ;
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              dbgHalt,
  output logic              svcPulse,
  output logic              alarmOut,
  output logic              rstReq
);
  wdCfg_t           cfgQ;
  cntStrobe_t       strobe;
  logic [DATA_W-1:0] cntVal;
  logic svcWr, almClrWr, atUpper, tooEarly;

  wdog_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .cntVal(cntVal), .cfg(cfgQ),
    .busRdata(busRdata), .svcWr(svcWr), .almClrWr(almClrWr)
  );

  wdog_dpath #(.CNT_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lower(cfgQ.lower),
    .upper(cfgQ.upper), .cntVal(cntVal), .atUpper(atUpper),
    .tooEarly(tooEarly)
  );

  wdog_ctrl #(.DATA_W(DATA_W), .PW_W(SPW_W), .KEY(FEED_KEY)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(cfgQ.enable), .prewarn(cfgQ.prewarn),
    .dbgRun(cfgQ.dbgRun), .spw(cfgQ.spw), .dbgHalt(dbgHalt),
    .svcWr(svcWr), .svcData(busWdata), .almClrWr(almClrWr),
    .atUpper(atUpper), .tooEarly(tooEarly), .strobe(strobe),
    .svcPulse(svcPulse), .alarmOut(alarmOut), .rstReq(rstReq)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          busWe,
  input logic [AW-1:0] busAddr,
  input logic [DW-1:0] busWdata,
  input logic          dbgHalt,
  input logic          svcPulse,
  input logic          alarmOut,
  input logic          rstReq,
  input logic [DW-1:0] cnt,
  input logic          cfgEnable,
  input logic          cfgDbgRun
);
  p_sticky_r13: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> rstReq);

  p_pulse_feed_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(svcPulse) |-> $past(busWe && busAddr == A_SVC && busWdata == FEED_KEY));

  p_alarm_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alarmOut) |-> $past(busWe && busAddr == A_CLR && busWdata[0]));

  p_alarm_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmOut) |-> (cnt == '0));

  p_disabled_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> $stable(cnt));

  p_halt_freeze_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && dbgHalt && !cfgDbgRun && !(busWe && busAddr == A_SVC)) |=> $stable(cnt));
endmodule

bind wdog_top wdog_chk chk_i (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .dbgHalt(dbgHalt), .svcPulse(svcPulse),
  .alarmOut(alarmOut), .rstReq(rstReq), .cnt(cntVal),
  .cfgEnable(cfgQ.enable), .cfgDbgRun(cfgQ.dbgRun)
);

// File: tb/wdog_top_tb_top.sv
`timescale 1ns/1ps
module wdog_top_tb_top;
  localparam logic [31:0] KEY = 32'hABADCAFE;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        dbgHalt = 1'b0;
  logic        svcPulse, alarmOut, rstReq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wdog_top dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .dbgHalt(dbgHalt),
    .svcPulse(svcPulse), .alarmOut(alarmOut), .rstReq(rstReq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    busWe = 1'b0; dbgHalt = 1'b0;
    @(negedge clk); rstN = 1'b0;
    tick(2); rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
    #0.1;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    busAddr = a; #0.1; d = busRdata;
  endtask

  task automatic waitCnt(logic [31:0] v);
    logic [31:0] c;
    for (int i = 0; i < 1000; i++) begin
      rd(3'd3, c);
      if (c == v) return;
      @(negedge clk);
    end
  endtask

  task automatic setup(logic [31:0] lo, logic [31:0] up, logic [31:0] ctl);
    doReset();
    wr(3'd1, lo); wr(3'd2, up); wr(3'd0, ctl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v0;
    int hi;

    // R1 reset state and counting
    doReset();
    rd(3'd3, v); check("R1 cnt reset", v, 0);
    check("R1 rstReq reset", {31'b0, rstReq}, 0);
    check("R1 alarm reset", {31'b0, alarmOut}, 0);
    check("R1 pulse reset", {31'b0, svcPulse}, 0);
    rd(3'd0, v); check("R1 ctrl reset", v, 0);
    rd(3'd1, v); check("R1 lower reset", v, 0);
    rd(3'd2, v); check("R1 upper reset", v, 32'hFFFF_FFFF);
    wr(3'd0, 32'h1); tick(7);
    rd(3'd3, v); check("R1 count 7", v, 7);

    // R2 R3 R4 feed sweep
    for (int ls = 0; ls < 2; ls++) begin
      for (int c = 0; c <= 8; c++) begin
        logic [31:0] lo;
        logic good;
        lo = (ls == 0) ? 32'd0 : 32'd3;
        good = (lo == 0) || (c >= lo);
        setup(lo, 32'd8, 32'h1);
        waitCnt(c);
        wr(3'd4, KEY);
        if (good) begin
          rd(3'd3, v);
          check(lo == 0 ? "R4 feed accepted cnt" : "R2 feed accepted cnt", v, 0);
          check("R2 no reset on good feed", {31'b0, rstReq}, 0);
          check("R10 pulse after feed", {31'b0, svcPulse}, 1);
        end else begin
          check("R3 early feed reset", {31'b0, rstReq}, 1);
        end
      end
    end

    // R10 pulse width
    for (int k = 0; k < 2; k++) begin
      logic [31:0] w;
      w = (k == 0) ? 32'd3 : 32'd16;
      setup(32'd0, 32'd100, 32'h1 | (w << 8));
      tick(2);
      wr(3'd4, KEY);
      hi = 0;
      for (int i = 0; i < 40; i++) begin
        if (svcPulse) hi++;
        @(negedge clk);
      end
      check("R10 pulse width", hi, w + 1);
    end

    // R6 timeout
    setup(32'd0, 32'd5, 32'h1);
    waitCnt(5);
    check("R6 no reset at upper", {31'b0, rstReq}, 0);
    tick(1);
    check("R6 reset after upper", {31'b0, rstReq}, 1);
    tick(10);
    check("R13 reset sticky", {31'b0, rstReq}, 1);
    wr(3'd4, KEY);
    check("R13 sticky after feed", {31'b0, rstReq}, 1);

    // R6 upper below lower
    setup(32'd6, 32'd3, 32'h1);
    waitCnt(3);
    check("R6 inverted no reset yet", {31'b0, rstReq}, 0);
    tick(1);
    check("R6 inverted bounds reset", {31'b0, rstReq}, 1);

    // R5 wrong key
    setup(32'd0, 32'd50, 32'h1);
    tick(2);
    wr(3'd4, 32'h1234_5678);
    check("R5 wrong key reset", {31'b0, rstReq}, 1);

    // R7 R9 R8: clear but no feed
    setup(32'd0, 32'd5, 32'h3);
    waitCnt(5); tick(1);
    check("R7 alarm set", {31'b0, alarmOut}, 1);
    check("R7 no reset first overrun", {31'b0, rstReq}, 0);
    rd(3'd3, v); check("R7 counter restarted", v, 0);
    wr(3'd5, 32'h1);
    check("R9 alarm cleared", {31'b0, alarmOut}, 0);
    waitCnt(5); tick(1);
    check("R8 reset no feed", {31'b0, rstReq}, 1);

    // R8 feed but alarm still set
    setup(32'd0, 32'd5, 32'h3);
    waitCnt(5); tick(1);
    wr(3'd4, KEY);
    check("R8 feed ok while alarm", {31'b0, rstReq}, 0);
    waitCnt(5); tick(1);
    check("R8 reset alarm still set", {31'b0, rstReq}, 1);

    // R8 clear and feed: overrun counts as first again
    setup(32'd0, 32'd5, 32'h3);
    waitCnt(5); tick(1);
    wr(3'd5, 32'h1);
    wr(3'd4, KEY);
    waitCnt(5); tick(1);
    check("R8 rearmed alarm", {31'b0, alarmOut}, 1);
    check("R8 rearmed no reset", {31'b0, rstReq}, 0);

    // R12 pause, resume, ignored feeds
    setup(32'd0, 32'd100, 32'h1);
    waitCnt(3);
    wr(3'd0, 32'h0);
    rd(3'd3, v0);
    tick(5);
    rd(3'd3, v); check("R12 paused holds", v, v0);
    wr(3'd4, 32'h1234_5678);
    check("R12 wrong key ignored", {31'b0, rstReq}, 0);
    wr(3'd4, KEY);
    rd(3'd3, v); check("R12 feed ignored", v, v0);
    check("R12 no pulse disabled", {31'b0, svcPulse}, 0);
    wr(3'd0, 32'h1);
    tick(1);
    rd(3'd3, v); check("R12 resumed", v, v0 + 1);

    // R11 debug freeze
    setup(32'd0, 32'd100, 32'h1);
    tick(2);
    dbgHalt = 1'b1;
    rd(3'd3, v0);
    tick(4);
    rd(3'd3, v); check("R11 frozen in halt", v, v0);
    wr(3'd0, 32'h11);
    tick(3);
    rd(3'd3, v); check("R11 runs with debug-run", v, v0 + 3);
    dbgHalt = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule